// File: doc/BRIEF.md
# Parallel Flash Program Sequencer

This block sits on the host side of an asynchronous, byte-wide parallel flash device. It takes one request at a time through a valid/ready handshake. A request can program a byte, erase one sector or erase the whole array. The block first plays out the unlock write sequence that the flash expects for that request. It then polls the flash until the internal operation has finished, and it reports the outcome with a one-cycle done pulse or a one-cycle error pulse.

All bus timing comes from parameters given in whole system-clock cycles. These are the setup before a write strobe, the width of the strobe, the recovery time after it, and the read access window. The flash drives the same data pins that the block writes on, so the block releases its data driver before it opens the flash outputs for a read.

Completion detection relies on the flash flipping DQ6 on every read while it is busy. Once DQ6 matches on two back-to-back reads, the block makes two more reads to guard against a read that caught the moment the flash finished. The operation counts as complete only if those two reads also agree. Each request type has its own limit on polling time.

Request handshake rules: a request moves across on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the cycle in which the outcome is reported. While `req_ready` is low, the requester keeps `req_valid`, `req_op`, `req_addr` and `req_data` steady or withdraws them. A request held during that time has no effect.

Top module: `flash_prog_seq`

## Requirements
- R1: Request code 2'b00 (program) produces exactly four bus writes in this order: address 5555h data AAh, address 2AAAh data 55h, address 5555h data A0h, and then the request address with the request data. Command addresses have all bits above bit 14 at zero.
- R2: Request code 2'b01 (sector erase) produces exactly six writes: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, and then the sector base with data 30h. The sector base is the request address with its low SECT_BITS bits cleared.
- R3: Request code 2'b10 (chip erase) produces the same first five writes as R2, followed by 5555h/10h.
- R4: For every write, the following hold. CE# is low and OE# is high. The data driver is on, with address and data steady, for at least SETUP_CYC cycles before WE# falls. WE# stays low for exactly WE_LOW_CYC cycles, and address and data do not change while it is low. WE# stays high for at least SETUP_CYC+WE_HIGH_CYC cycles between two strobes. OE# is never low while WE# is low.
- R5: For every polling read, CE# is low, WE# is high and the data driver is off. The driver is already off on the cycle before OE# falls and stays off while OE# is low. OE# stays low for exactly RD_ACC_CYC cycles.
- R6: Polling reads use the address of the final write: the request address for program, the sector base for sector erase, and 5555h for chip erase.
- R7: Completion is declared after the read where DQ6 has been equal on four consecutive reads (one matching pair plus two confirming reads). Any mismatch restarts the count, and no further read is made after completion.
- R8: A polling timer starts when the final write finishes. If a read completes without meeting R7 and the timer has reached the limit for the request type (PROG_TO_CYC, SECT_TO_CYC or CHIP_TO_CYC), the block reports an error instead of done.
- R9: `req_ready` is high exactly when the block is idle. A request offered while `req_ready` is low causes no bus activity and is not acted on later unless it is still offered when `req_ready` is high.
- R10: Each accepted request yields exactly one single-cycle pulse on either `done_o` or `err_o`, never both. `req_ready` is high in that cycle.
- R11: After reset, CE#, OE# and WE# are high, the data driver is off, `req_ready` is high, and `done_o` and `err_o` are low.
- R12: Request code 2'b11 is reserved. It is accepted, makes no bus access, and gives an `err_o` pulse in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| req_addr | input | AW | Target byte address or any address inside the sector |
| req_data | input | 8 | Byte to program |
| done_o | output | 1 | One-cycle pulse: operation completed |
| err_o | output | 1 | One-cycle pulse: timeout or reserved code |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enable for the data driver |
| fl_dq_in | input | 8 | Data returned by the flash |

## Verification
Assertions check the pin-level properties on every cycle:
- no overlap between the data driver and OE#;
- OE# held high during write strobes;
- address and data steady while WE# is low;
- an accepted real request pulling `req_ready` low;
- the reserved code producing an error in the next cycle;
- done and error never coinciding, and `req_ready` high when either is reported.

Only the bench scenarios can show the rest. These are the exact order and content of the unlock writes, the polling address, the number of reads needed as a function of how long the flash stays busy, where the timeout fires, and that a request held during a busy period is never replayed.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10,
    OP_RSVD = 2'b11
  } fs_op_e;

  typedef enum logic [2:0] {
    B_IDLE,
    B_WSET,
    B_WLOW,
    B_WHIGH,
    B_RTURN,
    B_RACC,
    B_RREC
  } fs_bus_st_e;

  typedef enum logic [2:0] {
    T_IDLE,
    T_WR_GO,
    T_WR_WAIT,
    T_RD_GO,
    T_RD_WAIT
  } fs_top_st_e;

  localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_A         = 8'hAA;
  localparam logic [7:0]  KEY_B         = 8'h55;
  localparam logic [7:0]  CMD_PROG      = 8'hA0;
  localparam logic [7:0]  CMD_ERASE     = 8'h80;
  localparam logic [7:0]  CMD_SECT      = 8'h30;
  localparam logic [7:0]  CMD_CHIP      = 8'h10;

endpackage

// File: rtl/fs_cmd_seq.sv
module fs_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int AW        = 19,
  parameter int SECT_BITS = 12
) (
  input  fs_op_e          op,
  input  logic [2:0]      step,
  input  logic [AW-1:0]   tgt_addr,
  input  logic [7:0]      tgt_data,
  output logic [AW-1:0]   cmd_addr,
  output logic [7:0]      cmd_data,
  output logic            last_step,
  output logic [AW-1:0]   poll_addr
);

  localparam logic [AW-1:0] ADDR_A = AW'(UNLOCK_ADDR_A);
  localparam logic [AW-1:0] ADDR_B = AW'(UNLOCK_ADDR_B);
  localparam logic [2:0]    PROG_LAST = 3'd3;
  localparam logic [2:0]    ERASE_LAST = 3'd5;

  logic [AW-1:0] sect_base;
  logic          is_prog;
  logic          is_sect;

  assign sect_base = {tgt_addr[AW-1:SECT_BITS], {SECT_BITS{1'b0}}};
  assign is_prog   = (op == OP_PROG);
  assign is_sect   = (op == OP_SECT);
  assign last_step = is_prog ? (step == PROG_LAST) : (step == ERASE_LAST);

  always_comb begin
    if (is_prog)      poll_addr = tgt_addr;
    else if (is_sect) poll_addr = sect_base;
    else              poll_addr = ADDR_A;
  end

  always_comb begin
    cmd_addr = ADDR_A;
    cmd_data = KEY_A;
    unique case (step)
      3'd0: begin cmd_addr = ADDR_A; cmd_data = KEY_A; end
      3'd1: begin cmd_addr = ADDR_B; cmd_data = KEY_B; end
      3'd2: begin cmd_addr = ADDR_A; cmd_data = is_prog ? CMD_PROG : CMD_ERASE; end
      3'd3: begin
        if (is_prog) begin cmd_addr = tgt_addr; cmd_data = tgt_data; end
        else         begin cmd_addr = ADDR_A;   cmd_data = KEY_A;    end
      end
      3'd4: begin cmd_addr = ADDR_B; cmd_data = KEY_B; end
      3'd5: begin
        if (is_sect) begin cmd_addr = sect_base; cmd_data = CMD_SECT; end
        else         begin cmd_addr = ADDR_A;    cmd_data = CMD_CHIP; end
      end
      default: begin cmd_addr = ADDR_A; cmd_data = KEY_A; end
    endcase
  end

endmodule

// File: rtl/fs_bus_engine.sv
module fs_bus_engine
  import flash_seq_pkg::*;
#(
  parameter int AW          = 19,
  parameter int SETUP_CYC   = 1,
  parameter int WE_LOW_CYC  = 4,
  parameter int WE_HIGH_CYC = 3,
  parameter int RD_ACC_CYC  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_read,
  input  logic [AW-1:0] op_addr,
  input  logic [7:0]    op_data,
  output logic          done,
  output logic [7:0]    rd_data,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    dq_out,
  input  logic [7:0]    dq_in
);

  localparam int MAX_A = (SETUP_CYC > WE_LOW_CYC) ? SETUP_CYC : WE_LOW_CYC;
  localparam int MAX_B = (WE_HIGH_CYC > RD_ACC_CYC) ? WE_HIGH_CYC : RD_ACC_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] L_SET  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] L_LOW  = CW'(WE_LOW_CYC - 1);
  localparam logic [CW-1:0] L_HIGH = CW'(WE_HIGH_CYC - 1);
  localparam logic [CW-1:0] L_ACC  = CW'(RD_ACC_CYC - 1);

  fs_bus_st_e    st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [7:0]    rd_q;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= B_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
    end else begin
      unique case (st)
        B_IDLE: begin
          if (start) begin
            addr_q <= op_addr;
            data_q <= op_data;
            if (is_read) begin
              st  <= B_RTURN;
              cnt <= '0;
            end else begin
              st  <= B_WSET;
              cnt <= L_SET;
            end
          end
        end
        B_WSET: begin
          if (cnt_zero) begin st <= B_WLOW; cnt <= L_LOW; end
          else cnt <= cnt - 1'b1;
        end
        B_WLOW: begin
          if (cnt_zero) begin st <= B_WHIGH; cnt <= L_HIGH; end
          else cnt <= cnt - 1'b1;
        end
        B_WHIGH: begin
          if (cnt_zero) st <= B_IDLE;
          else cnt <= cnt - 1'b1;
        end
        B_RTURN: begin
          st  <= B_RACC;
          cnt <= L_ACC;
        end
        B_RACC: begin
          if (cnt_zero) begin st <= B_RREC; rd_q <= dq_in; end
          else cnt <= cnt - 1'b1;
        end
        B_RREC:  st <= B_IDLE;
        default: st <= B_IDLE;
      endcase
    end
  end

  assign ce_n     = (st == B_IDLE);
  assign we_n     = (st != B_WLOW);
  assign oe_n     = (st != B_RACC);
  assign dq_oe    = (st == B_WSET) || (st == B_WLOW) || (st == B_WHIGH);
  assign bus_addr = addr_q;
  assign dq_out   = data_q;
  assign rd_data  = rd_q;
  assign done     = ((st == B_WHIGH) && cnt_zero) || (st == B_RREC);

  // R5: flash outputs never open while the data driver is on
  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);

  // R4: output enable stays high for the whole strobe
  a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (oe_n && !ce_n));

  // R4: address and data held across the strobe
  a_r4_stable_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> ($stable(bus_addr) && $stable(dq_out)));

endmodule

// File: rtl/fs_poll_track.sv
module fs_poll_track #(
  parameter int TW           = 24,
  parameter int VERIFY_READS = 2,
  parameter int TOGGLE_BIT   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sample,
  input  logic [7:0]    rd_byte,
  input  logic [TW-1:0] limit,
  output logic          finished,
  output logic          timed_out
);

  localparam int NEED = VERIFY_READS + 1;
  localparam int RW   = $clog2(NEED + 1);
  localparam logic [RW-1:0] RUN_DONE = RW'(NEED - 1);

  logic          prev_bit;
  logic          have_prev;
  logic [RW-1:0] run;
  logic [TW-1:0] tmo_cnt;
  logic          cur_bit;
  logic          match;
  logic          rd_unused;

  assign cur_bit   = rd_byte[TOGGLE_BIT];
  assign rd_unused = ^rd_byte;
  assign match     = have_prev && (cur_bit == prev_bit);
  assign finished  = sample && match && (run == RUN_DONE);
  assign timed_out = sample && !finished && (tmo_cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_bit  <= 1'b0;
      have_prev <= 1'b0;
      run       <= '0;
      tmo_cnt   <= '0;
    end else if (clear) begin
      have_prev <= 1'b0;
      run       <= '0;
      tmo_cnt   <= '0;
    end else begin
      if (tmo_cnt != {TW{1'b1}}) tmo_cnt <= tmo_cnt + 1'b1;
      if (sample) begin
        prev_bit  <= cur_bit;
        have_prev <= 1'b1;
        run       <= match ? run + 1'b1 : '0;
      end
    end
  end

  // R7: a single read can never end polling on its own
  a_r7_first_read_not_final: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !have_prev) |-> !finished);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int AW           = 19,
  parameter int SECT_BITS    = 12,
  parameter int SETUP_CYC    = 1,
  parameter int WE_LOW_CYC   = 4,
  parameter int WE_HIGH_CYC  = 3,
  parameter int RD_ACC_CYC   = 7,
  parameter int VERIFY_READS = 2,
  parameter int PROG_TO_CYC  = 2000,
  parameter int SECT_TO_CYC  = 2500000,
  parameter int CHIP_TO_CYC  = 10000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          done_o,
  output logic          err_o,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in
);

  localparam int MAX_PS = (PROG_TO_CYC > SECT_TO_CYC) ? PROG_TO_CYC : SECT_TO_CYC;
  localparam int MAX_TO = (MAX_PS > CHIP_TO_CYC) ? MAX_PS : CHIP_TO_CYC;
  localparam int TW     = $clog2(MAX_TO + 2);

  fs_top_st_e    st;
  fs_op_e        op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [2:0]    step_q;
  logic          done_q;
  logic          err_q;

  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic          last_step;
  logic [AW-1:0] poll_addr;

  logic          eng_start;
  logic          eng_read;
  logic          eng_done;
  logic [7:0]    eng_rd;
  logic          poll_clear;
  logic          poll_sample;
  logic          poll_fin;
  logic          poll_tmo;
  logic [TW-1:0] limit;
  logic          accept;

  assign req_ready = (st == T_IDLE);
  assign accept    = req_valid && req_ready;

  fs_cmd_seq #(.AW(AW), .SECT_BITS(SECT_BITS)) u_cmd (
    .op        (op_q),
    .step      (step_q),
    .tgt_addr  (addr_q),
    .tgt_data  (data_q),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .last_step (last_step),
    .poll_addr (poll_addr)
  );

  assign eng_start = (st == T_WR_GO) || (st == T_RD_GO);
  assign eng_read  = (st == T_RD_GO);

  fs_bus_engine #(
    .AW(AW), .SETUP_CYC(SETUP_CYC), .WE_LOW_CYC(WE_LOW_CYC),
    .WE_HIGH_CYC(WE_HIGH_CYC), .RD_ACC_CYC(RD_ACC_CYC)
  ) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (eng_start),
    .is_read  (eng_read),
    .op_addr  (eng_read ? poll_addr : cmd_addr),
    .op_data  (cmd_data),
    .done     (eng_done),
    .rd_data  (eng_rd),
    .ce_n     (fl_ce_n),
    .oe_n     (fl_oe_n),
    .we_n     (fl_we_n),
    .dq_oe    (fl_dq_oe),
    .bus_addr (fl_addr),
    .dq_out   (fl_dq_out),
    .dq_in    (fl_dq_in)
  );

  always_comb begin
    unique case (op_q)
      OP_PROG: limit = TW'(PROG_TO_CYC);
      OP_SECT: limit = TW'(SECT_TO_CYC);
      default: limit = TW'(CHIP_TO_CYC);
    endcase
  end

  assign poll_clear  = (st == T_WR_WAIT) && eng_done && last_step;
  assign poll_sample = (st == T_RD_WAIT) && eng_done;

  fs_poll_track #(.TW(TW), .VERIFY_READS(VERIFY_READS), .TOGGLE_BIT(6)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (poll_clear),
    .sample    (poll_sample),
    .rd_byte   (eng_rd),
    .limit     (limit),
    .finished  (poll_fin),
    .timed_out (poll_tmo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= T_IDLE;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      step_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st)
        T_IDLE: begin
          if (accept) begin
            op_q   <= fs_op_e'(req_op);
            addr_q <= req_addr;
            data_q <= req_data;
            step_q <= '0;
            if (fs_op_e'(req_op) == OP_RSVD) err_q <= 1'b1;
            else st <= T_WR_GO;
          end
        end
        T_WR_GO:   st <= T_WR_WAIT;
        T_WR_WAIT: begin
          if (eng_done) begin
            if (last_step) st <= T_RD_GO;
            else begin
              step_q <= step_q + 1'b1;
              st     <= T_WR_GO;
            end
          end
        end
        T_RD_GO:   st <= T_RD_WAIT;
        T_RD_WAIT: begin
          if (eng_done) begin
            if (poll_fin) begin
              done_q <= 1'b1;
              st     <= T_IDLE;
            end else if (poll_tmo) begin
              err_q <= 1'b1;
              st    <= T_IDLE;
            end else begin
              st <= T_RD_GO;
            end
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  // R9: a real request takes the block out of idle
  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_op != 2'b11)) |=> !req_ready);

  // R9: the bus is quiet whenever a new request may be taken
  a_r9_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe));

  // R10: one outcome per report cycle, with the block idle
  a_r10_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> (!(done_o && err_o) && req_ready));

  // R12: reserved code answered in the next cycle
  a_r12_reserved_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_op == 2'b11)) |=> err_o);

endmodule

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW        = 16;
  localparam int SB        = 12;
  localparam int SETUP     = 1;
  localparam int WLOW      = 2;
  localparam int WHIGH     = 2;
  localparam int RACC      = 3;
  localparam int PROG_TO   = 200;
  localparam int SECT_TO   = 300;
  localparam int CHIP_TO   = 400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          done_o, err_o;
  logic          fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dq_out;
  logic [7:0]    fl_dq_in = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_seq #(
    .AW(AW), .SECT_BITS(SB), .SETUP_CYC(SETUP), .WE_LOW_CYC(WLOW),
    .WE_HIGH_CYC(WHIGH), .RD_ACC_CYC(RACC), .VERIFY_READS(2),
    .PROG_TO_CYC(PROG_TO), .SECT_TO_CYC(SECT_TO), .CHIP_TO_CYC(CHIP_TO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .done_o(done_o), .err_o(err_o), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- flash model, sampled at the falling clock edge
  int            scn_id = 0;
  int            model_busy = 0;
  logic [AW-1:0] exp_poll = '0;

  int            seen_id = 0;
  logic [AW-1:0] wr_a [0:7];
  logic [7:0]    wr_d [0:7];
  int            wr_cnt, rd_cnt, rd_bad_addr, viol4, viol5;
  int            setup_cnt, low_cnt, hi_cnt, oe_low_cnt, last_rise;
  logic          p_we, p_oe, p_dqoe;
  logic [AW-1:0] f_addr;
  logic [7:0]    f_data;

  always @(negedge clk) begin
    if (!rst_n || seen_id != scn_id) begin
      seen_id = scn_id;
      wr_cnt = 0; rd_cnt = 0; rd_bad_addr = 0; viol4 = 0; viol5 = 0;
      setup_cnt = 0; low_cnt = 0; hi_cnt = 1000; oe_low_cnt = 0; last_rise = 0;
      p_we = 1'b1; p_oe = 1'b1; p_dqoe = 1'b0;
    end else begin
      if (!fl_we_n && p_we) begin
        if (fl_ce_n || !fl_oe_n || !fl_dq_oe) viol4++;
        if (setup_cnt < SETUP) viol4++;
        if (hi_cnt < SETUP + WHIGH) viol4++;
        f_addr = fl_addr; f_data = fl_dq_out; low_cnt = 1;
      end else if (!fl_we_n) begin
        low_cnt++;
        if (fl_addr != f_addr || fl_dq_out != f_data || !fl_oe_n) viol4++;
      end
      if (fl_we_n && !p_we) begin
        if (low_cnt != WLOW) viol4++;
        if (wr_cnt < 8) begin wr_a[wr_cnt] = f_addr; wr_d[wr_cnt] = f_data; end
        wr_cnt++;
        hi_cnt = 1; last_rise = cyc;
      end else if (fl_we_n) hi_cnt++;
      setup_cnt = (!fl_ce_n && fl_we_n && fl_oe_n && fl_dq_oe) ? setup_cnt + 1 : 0;

      if (!fl_oe_n && p_oe) begin
        if (p_dqoe || fl_dq_oe || fl_ce_n || !fl_we_n) viol5++;
        if (fl_addr != exp_poll) rd_bad_addr++;
        rd_cnt++;
        oe_low_cnt = 1;
        if (rd_cnt <= model_busy) fl_dq_in = (rd_cnt % 2 == 1) ? 8'hC1 : 8'h81;
        else fl_dq_in = 8'h3C;
      end else if (!fl_oe_n) begin
        oe_low_cnt++;
        if (fl_dq_oe) viol5++;
      end
      if (fl_oe_n && !p_oe && oe_low_cnt != RACC) viol5++;
      p_we = fl_we_n; p_oe = fl_oe_n; p_dqoe = fl_dq_oe;
    end
  end

  // ---------------- expected values from the requirements
  function automatic logic [23:0] exp_write(input int op, input int idx,
                                            input logic [15:0] a, input logic [7:0] d);
    logic [15:0] sb;
    sb = a & 16'hF000;
    case (idx)
      0: return {16'h5555, 8'hAA};
      1: return {16'h2AAA, 8'h55};
      2: return {16'h5555, (op == 0) ? 8'hA0 : 8'h80};
      3: return (op == 0) ? {a, d} : {16'h5555, 8'hAA};
      4: return {16'h2AAA, 8'h55};
      default: return (op == 1) ? {sb, 8'h30} : {16'h5555, 8'h10};
    endcase
  endfunction

  function automatic int exp_reads(input int b);
    int run = 0;
    int prev = 0;
    for (int k = 1; k < 100000; k++) begin
      int v;
      v = (k <= b) ? k % 2 : 0;
      if (k > 1 && v == prev) run++; else run = 0;
      prev = v;
      if (run == 3) return k;
    end
    return -1;
  endfunction

  task automatic run_op(input int op, input logic [15:0] a, input logic [7:0] d,
                        input int busy, input bit want_err);
    int waitc;
    int n_wr;
    int lim;
    bit got_done, got_err;
    logic [23:0] ew;
    n_wr = (op == 0) ? 4 : 6;
    lim  = (op == 0) ? PROG_TO : (op == 1) ? SECT_TO : CHIP_TO;
    scn_id++;
    model_busy = busy;
    exp_poll = (op == 0) ? a : (op == 1) ? (a & 16'hF000) : 16'h5555;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    waitc = 0;
    while (!done_o && !err_o && waitc < 5000) begin
      @(negedge clk);
      waitc++;
    end
    got_done = done_o; got_err = err_o;
    check(req_ready == 1'b1, "R10 ready in report cycle", req_ready, 1);
    if (want_err) begin
      check(got_err && !got_done, "R8 timeout reported", {got_done, got_err}, 2'b01);
      check((cyc - last_rise) >= lim && (cyc - last_rise) <= lim + 30,
            "R8 timeout position", cyc - last_rise, lim);
    end else begin
      check(got_done && !got_err, "R7 done reported", {got_done, got_err}, 2'b10);
      check(rd_cnt == exp_reads(busy), "R7 read count", rd_cnt, exp_reads(busy));
    end
    @(negedge clk);
    check(!done_o && !err_o, "R10 single-cycle report", {done_o, err_o}, 0);
    check(wr_cnt == n_wr, (op == 0) ? "R1 write count" : (op == 1) ? "R2 write count"
                                    : "R3 write count", wr_cnt, n_wr);
    for (int i = 0; i < n_wr && i < 8; i++) begin
      ew = exp_write(op, i, a, d);
      check({wr_a[i], wr_d[i]} == ew, (op == 0) ? "R1 write content" :
            (op == 1) ? "R2 write content" : "R3 write content", {wr_a[i], wr_d[i]}, ew);
    end
    check(viol4 == 0, "R4 write timing", viol4, 0);
    check(viol5 == 0, "R5 read timing", viol5, 0);
    check(rd_bad_addr == 0, "R6 poll address", rd_bad_addr, 0);
  endtask

  bit wd_hit = 0;
  initial begin
    #(CLK_PERIOD * 150000);
    wd_hit = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ready_hi;
    int bus_act;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R11 bus idle in reset",
          {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !done_o && !err_o, "R11 status after reset",
          {req_ready, done_o, err_o}, 3'b100);

    // sweep: every request type against busy lengths 0..8
    for (int op = 0; op < 3; op++) begin
      for (int b = 0; b <= 8; b++) begin
        run_op(op, 16'(16'h1234 + b * 16'h0931 + op * 16'h2000), 8'(8'h5A ^ (b * 7)), b, 1'b0);
      end
    end

    // R8: flash that never finishes, per request type
    for (int op = 0; op < 3; op++) run_op(op, 16'hBEEF, 8'h11, 100000, 1'b1);

    // R12: reserved code
    scn_id++;
    model_busy = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b11; req_addr = 16'h4000; req_data = 8'h00;
    @(negedge clk);
    req_valid = 1'b0;
    check(err_o && !done_o && req_ready, "R12 reserved error pulse", {err_o, done_o}, 2'b10);
    repeat (5) @(negedge clk);
    check(wr_cnt == 0 && rd_cnt == 0, "R12 no bus access", wr_cnt + rd_cnt, 0);

    // R9: request offered while busy is not taken
    scn_id++;
    model_busy = 6;
    exp_poll = 16'h0777;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b00; req_addr = 16'h0777; req_data = 8'hC3;
    @(negedge clk);
    req_op = 2'b10;
    ready_hi = 0;
    for (int i = 0; i < 5000 && !done_o && !err_o; i++) begin
      if (req_ready) ready_hi++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(ready_hi == 0, "R9 ready low while busy", ready_hi, 0);
    check(done_o == 1'b1, "R9 held request does not disturb op", done_o, 1);
    bus_act = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!fl_ce_n) bus_act++;
    end
    check(wr_cnt == 4, "R9 only first request written", wr_cnt, 4);
    check(bus_act == 0, "R9 no replay after done", bus_act, 0);

    if (!wd_hit) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule